// File: doc/BRIEF.md
# Serial-Loaded Cellular Automaton Engine

This block runs Conway's Game of Life on an 8x8 grid of one-bit cells. Before the run, a host shifts the starting pattern in over a one-bit data line, one cell per clock, in row-major order. Raising the start input ends loading for good. From then on the engine repeats two steps with no further input: one update clock, then a 64-clock readout.

In the update clock, the engine computes the next state of every cell at once from the serial chain. It captures that generation in a separate parallel register. In each readout clock it presents one cell of the new generation on a one-bit value output, together with that cell's 1-based position on a 7-bit location output. The same cell is fed back into the tail of the load chain. After 64 readout clocks the chain holds the new generation in the same arrangement as a fresh load, and the next update clock begins.

The readout is a stream that cannot be stalled. A location value other than 0 marks a valid cell, and there is no ready input and no back-pressure. A consumer must accept one cell on every readout clock.

Top module: `life_engine`

## Requirements
- R1: During loading, each clock with start low shifts `data_i` into the grid. Once at least 64 bits have been loaded, the oldest of the last 64 becomes location 1. Location L (1..64) is row (L-1)/8, column (L-1)%8, with row 0 at the top and column 0 at the left.
- R2: If more than 64 bits are loaded, only the last 64 are kept. If fewer are loaded, the cells that were not written stay 0 from reset and take the lowest locations.
- R3: A clock in which `start_i` is high during loading does not load `data_i`. After that clock, `data_i` and `start_i` have no effect on the outputs until reset.
- R4: Each new generation follows the Life rule. A live cell with 2 or 3 live neighbours stays live. A dead cell with exactly 3 live neighbours becomes live. Every other cell is dead. Cells beyond the grid edge count as dead, with no wraparound.
- R5: The clock after start is an update clock, with `loc_o` = 0. Exactly one update clock separates consecutive readouts.
- R6: A readout lasts exactly 64 clocks. `loc_o` counts 1, 2, …, 64, and in each clock `cell_o` carries the new state of the cell at that location.
- R7: The generation that was read out is the input to the next update, so readouts show successive generations indefinitely.
- R8: While loading, `cell_o` and `loc_o` are 0.
- R9: Synchronous reset (`rst` high) clears both grid registers and the sequencer and returns the engine to loading. If `start_i` is already high when reset is released, the engine runs from an all-zero grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 1 | Serial cell value while loading |
| start_i | input | 1 | Level input that starts the simulation |
| cell_o | output | 1 | Cell value during readout |
| loc_o | output | 7 | Location 1..64 during readout, 0 otherwise |

## Verification
A wrong bit in the load chain or the capture register shows on `cell_o` no later than the next readout. The bench checks every cell of every generation against its own Life model, so an ordering error in the shift direction appears as a mismatch at a specific location. A sequencer fault, such as a missed or extra update clock or a counter that stops short, shows at once as a broken 0, 1..64, 0 pattern on `loc_o`. A stuck-at bit in the neighbour logic usually takes a generation or two to surface, so the bench runs several generations from random and edge-touching patterns.

// File: rtl/life_pkg.sv
package life_pkg;

  // Operating phase of the engine.
  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,  // serial fill from the data line
    PH_UPDATE = 2'd1,  // one clock: parallel next-generation capture
    PH_SHOW   = 2'd2   // one cell per clock presented and recirculated
  } phase_e;

endpackage

// File: rtl/life_seq.sv
module life_seq
  import life_pkg::*;
#(
  parameter int CELLS = 64,
  localparam int CNT_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELLS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LOAD;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          // start is a level: once seen, loading never resumes
          if (start_i) phase_q <= PH_UPDATE;
        end
        PH_UPDATE: begin
          phase_q <= PH_SHOW;
          idx_q   <= '0;
        end
        PH_SHOW: begin
          if (idx_q == LAST_IDX) begin
            phase_q <= PH_UPDATE;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/life_load_chain.sv
module life_load_chain #(
  parameter int CELLS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_i,
  output logic [CELLS-1:0] grid_o
);

  // Bits enter at the top index and move toward index 0. After CELLS
  // shifts, the first bit in sits at index 0, which is location 1.
  logic [CELLS-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {bit_i, chain_q[CELLS-1:1]};
    end
  end

  assign grid_o = chain_q;

endmodule

// File: rtl/life_next_gen.sv
module life_next_gen #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS
) (
  input  logic [CELLS-1:0] cur_i,
  output logic [CELLS-1:0] nxt_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [8:0] nb;
      logic [3:0] live_cnt;

      // Nine-slot window around (r,c); the centre and any slot past
      // the edge tie off to 0.
      for (genvar k = 0; k < 9; k++) begin : g_nb
        localparam int RR = r + (k / 3) - 1;
        localparam int CC = c + (k % 3) - 1;
        if (k == 4 || RR < 0 || RR >= ROWS || CC < 0 || CC >= COLS) begin : g_off
          assign nb[k] = 1'b0;
        end else begin : g_on
          assign nb[k] = cur_i[RR*COLS + CC];
        end
      end

      always_comb begin
        live_cnt = 4'($countones(nb));
      end

      assign nxt_o[r*COLS + c] = (live_cnt == 4'd3) |
                                 (cur_i[r*COLS + c] & (live_cnt == 4'd2));
    end
  end

endmodule

// File: rtl/life_update_reg.sv
module life_update_reg #(
  parameter int CELLS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic [CELLS-1:0] gen_i,
  output logic             head_o
);

  // Captured in parallel, drained from index 0 upward.
  logic [CELLS-1:0] gen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= '0;
    end else if (cap_en) begin
      gen_q <= gen_i;
    end else if (shift_en) begin
      gen_q <= {1'b0, gen_q[CELLS-1:1]};
    end
  end

  assign head_o = gen_q[0];

endmodule

// File: rtl/life_engine.sv
module life_engine
  import life_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int LOC_W = $clog2(CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_i,
  input  logic             start_i,
  output logic             cell_o,
  output logic [LOC_W-1:0] loc_o
);

  localparam int CNT_W = $clog2(CELLS);

  phase_e           phase;
  logic [CNT_W-1:0] idx;
  logic [CELLS-1:0] grid;
  logic [CELLS-1:0] next_grid;
  logic             head;
  logic             in_load;
  logic             in_update;
  logic             in_show;
  logic             chain_en;
  logic             chain_bit;

  life_seq #(.CELLS(CELLS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .phase_o (phase),
    .idx_o   (idx)
  );

  assign in_load   = (phase == PH_LOAD);
  assign in_update = (phase == PH_UPDATE);
  assign in_show   = (phase == PH_SHOW);

  // The chain takes user data while loading (not on the start clock)
  // and recirculates the new generation during readout.
  assign chain_en  = (in_load & ~start_i) | in_show;
  assign chain_bit = in_show ? head : data_i;

  life_load_chain #(.CELLS(CELLS)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (chain_en),
    .bit_i    (chain_bit),
    .grid_o   (grid)
  );

  life_next_gen #(.ROWS(ROWS), .COLS(COLS)) u_rule (
    .cur_i (grid),
    .nxt_o (next_grid)
  );

  life_update_reg #(.CELLS(CELLS)) u_upd (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (in_update),
    .shift_en (in_show),
    .gen_i    (next_grid),
    .head_o   (head)
  );

  assign cell_o = in_show & head;
  assign loc_o  = in_show ? (LOC_W'(idx) + LOC_W'(1)) : '0;

endmodule

// File: rtl/life_engine_chk.sv
module life_engine_chk #(
  parameter int CELLS = 64,
  parameter int LOC_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             cell_o,
  input logic [LOC_W-1:0] loc_o,
  input logic             in_load,
  input logic             in_update
);

  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(CELLS);

  a_r8_load_quiet: assert property (@(posedge clk) disable iff (rst)
    in_load |-> (loc_o == '0 && !cell_o));

  a_r5_update_loc_zero: assert property (@(posedge clk) disable iff (rst)
    in_update |-> loc_o == '0);

  a_r5_update_then_first: assert property (@(posedge clk) disable iff (rst)
    in_update |=> loc_o == LOC_W'(1));

  a_r6_loc_step: assert property (@(posedge clk) disable iff (rst)
    (loc_o != '0 && loc_o != LAST_LOC) |=> loc_o == $past(loc_o) + LOC_W'(1));

  a_r6_last_to_update: assert property (@(posedge clk) disable iff (rst)
    (loc_o == LAST_LOC) |=> in_update);

  a_r3_start_leaves_load: assert property (@(posedge clk) disable iff (rst)
    (in_load && start_i) |=> in_update);

  a_r3_no_return_to_load: assert property (@(posedge clk) disable iff (rst)
    !in_load |=> !in_load);

  a_r9_reset_to_load: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> in_load);

endmodule

bind life_engine life_engine_chk #(.CELLS(CELLS), .LOC_W(LOC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .cell_o    (cell_o),
  .loc_o     (loc_o),
  .in_load   (in_load),
  .in_update (in_update)
);

// File: tb/tb_life_engine.sv
module tb_life_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       data_i = 1'b0;
  logic       start_i = 1'b0;
  logic       cell_o;
  logic [6:0] loc_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic hist [0:255];
  int   nload = 0;

  always #10 clk = ~clk;

  life_engine dut (
    .clk(clk), .rst(rst), .data_i(data_i), .start_i(start_i),
    .cell_o(cell_o), .loc_o(loc_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Grid from the load history: last 64 bits, oldest at location 1.
  function automatic logic [63:0] loaded_grid();
    logic [63:0] g;
    for (int i = 0; i < 64; i++) begin
      int src = nload - 64 + i;
      g[i] = (src >= 0) ? hist[src] : 1'b0;
    end
    return g;
  endfunction

  function automatic logic [63:0] life_step(input logic [63:0] g);
    logic [63:0] n;
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        int cnt = 0;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            if ((dr != 0 || dc != 0) && r + dr >= 0 && r + dr < 8 &&
                c + dc >= 0 && c + dc < 8)
              cnt += int'(g[(r + dr) * 8 + c + dc]);
          end
        end
        n[r * 8 + c] = (cnt == 3) || (g[r * 8 + c] && cnt == 2);
      end
    end
    return n;
  endfunction

  // Ends at a negedge with reset released; start held at st.
  task automatic do_reset(input bit st);
    @(negedge clk);
    rst = 1'b1; start_i = st; data_i = 1'b0;
    repeat (3) @(negedge clk);
    check(loc_o == 7'd0 && cell_o == 1'b0, "R9 reset outputs", int'(loc_o), 0);
    rst = 1'b0;
    nload = 0;
  endtask

  // Called at a negedge; one load clock.
  task automatic load_bit(input logic b);
    data_i = b; start_i = 1'b0;
    hist[nload] = b;
    nload++;
    @(negedge clk);
    check(loc_o == 7'd0 && cell_o == 1'b0, "R8 quiet while loading",
          int'({loc_o, cell_o}), 0);
  endtask

  // Start clock: data_i deliberately 1 and must not load (R3).
  task automatic start_run();
    data_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
  endtask

  // Called at a negedge inside an update clock; ends in the next one.
  task automatic show_gen(input logic [63:0] g, input string tag);
    check(loc_o == 7'd0, "R5 update clock loc", int'(loc_o), 0);
    for (int k = 0; k < 64; k++) begin
      data_i = 1'($urandom);
      start_i = 1'($urandom);  // R3: ignored while running
      @(negedge clk);
      check(loc_o == 7'(k + 1), "R6 location sequence", int'(loc_o), k + 1);
      check(cell_o == g[k], tag, int'(cell_o), int'(g[k]));
    end
    @(negedge clk);
  endtask

  task automatic run_gens(input int n, input string tag);
    logic [63:0] g = life_step(loaded_grid());
    for (int i = 0; i < n; i++) begin
      show_gen(g, tag);
      g = life_step(g);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // Random fill with overflow: 70 loads keep the last 64 (R1, R2, R3, R4, R7)
    do_reset(1'b0);
    for (int i = 0; i < 70; i++) load_bit(1'($urandom));
    start_run();
    run_gens(4, "R2 R4 R7 overflow random gens");

    // Short load of 20 bits: earlier cells stay 0 (R2, R9)
    do_reset(1'b0);
    for (int i = 0; i < 20; i++) load_bit(1'($urandom_range(0, 1)));
    start_run();
    run_gens(2, "R2 R9 partial load gens");

    // Edge patterns: blinker on the top row, block in the bottom-right
    // corner, glider near the left edge (R1 ordering, R4 edges dead)
    do_reset(1'b0);
    begin
      logic [63:0] p = '0;
      p[0] = 1; p[1] = 1; p[2] = 1;          // row 0, cols 0..2
      p[54] = 1; p[55] = 1; p[62] = 1; p[63] = 1;
      p[25] = 1; p[34] = 1; p[40] = 1; p[41] = 1; p[42] = 1;
      for (int i = 0; i < 64; i++) load_bit(p[i]);
    end
    start_run();
    run_gens(5, "R1 R4 edge pattern gens");

    // Dense random 64-load (R1, R6, R7)
    do_reset(1'b0);
    for (int i = 0; i < 64; i++) load_bit(($urandom_range(0, 3) != 0));
    start_run();
    run_gens(3, "R1 R7 dense random gens");

    // Start high across reset release: all-zero run (R9)
    do_reset(1'b1);
    @(negedge clk);
    run_gens(2, "R9 start at reset release");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule